// File: doc/BRIEF.md
# System Controller with Machine Timer

This peripheral sits on a simple 32-bit register bus that carries per-byte write strobes. It gathers the small pieces of system state that software needs in one place.

- **Identification:** read-only build identification made of version bytes and a 32-bit build hash.
- **RAM status:** a live view of two RAM-initialization status inputs.
- **GPIO:** a single general-purpose output bit.
- **Simulation hooks:** a pair of hooks that print a character or end the run in simulation. Both are compiled away in hardware.
- **Machine timer:** a 64-bit counter that advances every clock. It is compared without sign against a 64-bit compare register, and the result drives a level timer-interrupt line.

Software reads the identification words to learn which build it runs on. It polls the status byte before using RAM. It drives the GPIO bit for a status indicator and programs the compare register to schedule timer interrupts. The bus is addressed in bytes, and the controller decodes 32-bit words. Each read returns its data one clock after the request, and that data holds until the next read.

Top module: `sysctl`

## Requirements
- R1: Word 0x00 reads as {misc, major, minor, revision}, with revision in bits 7:0 and misc in bits 31:24. Misc bit 7 (word bit 31) is the modified-sources flag and the other misc bits are 0. Writes to this word change nothing.
- R2: Word 0x04 reads as the 32-bit build hash parameter. It is read-only.
- R3: Byte 0x0A (bits 23:16 of word 0x08) reads the live RAM status. Bit 16 is init-done and bit 17 is init-error. Every other bit of word 0x08 reads 0.
- R4: A write to byte 0x08 (lane 0) prints its byte in simulation, and a write to byte 0x09 (lane 1) ends the run. When hooks are compiled out, these writes change no register, output or readback.
- R5: Bit 0 of word 0x10 is the GPIO output, and it reads back in bit 0. It resets to 0 and changes only on a write to that word with lane 0 enabled.
- R6: The 64-bit time counter (low half at 0x20, high half at 0x24) resets to 0. It increments by one every clock, and the carry passes from the low half into the high half.
- R7: A write to either half of the time counter loads the strobed bytes. No increment takes place in that clock, so a read issued in the very next cycle returns the written value.
- R8: The 64-bit compare register (low half at 0x28, high half at 0x2C) resets to all ones and is writable.
- R9: The timer interrupt is high exactly while the counter is greater than or equal to the compare value, compared as unsigned. It follows the registers in the same cycle.
- R10: Write strobe bit n updates only bits 8n+7:8n of the addressed word.
- R11: Reads of unmapped words return 0, and writes to them change nothing.
- R12: Read data appears on the clock edge that accepts the read. It holds through idle cycles and writes until the next read, and it is 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Bus request present this cycle |
| req_we_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | ADDR_W | Byte address; bits 1:0 ignored |
| req_wdata_i | input | 32 | Write data |
| req_strb_i | input | 4 | Byte write enables |
| rsp_rdata_o | output | 32 | Registered read data |
| ram_init_done_i | input | 1 | RAM initialization finished |
| ram_init_err_i | input | 1 | RAM initialization saw errors |
| gpio_o | output | 1 | General-purpose output bit |
| timer_irq_o | output | 1 | Level timer interrupt |

## Verification
The bench builds the block with distinct revision, minor and major bytes, a non-trivial hash and the modified-sources flag set. A swapped byte lane or a missing flag bit therefore shows up as a wrong readback. The hooks are compiled out (SIM_HOOKS = 0), so writes to the print and exit bytes can be checked as harmless without the run ending. Writes to the 32-bit halves of the counter put the low-to-high carry and the compare crossing within a few cycles of each other.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;

    localparam int BUS_W  = 32;
    localparam int STRB_W = BUS_W / 8;
    localparam int TMR_W  = 2 * BUS_W;

    // Word indices (byte offset / 4) of the mapped registers
    localparam int W_ID       = 0;
    localparam int W_HASH     = 1;
    localparam int W_SIM      = 2;
    localparam int W_GPIO     = 4;
    localparam int W_MTIME_LO = 8;
    localparam int W_MTIME_HI = 9;
    localparam int W_CMP_LO   = 10;
    localparam int W_CMP_HI   = 11;

    typedef struct packed {
        logic [TMR_W-1:0] mtime;
        logic [TMR_W-1:0] cmp;
    } tmr_state_t;

    typedef struct packed {
        logic             gpio;
        logic [BUS_W-1:0] rdata;
    } ctl_state_t;

    // Replace the strobed byte lanes of cur with those of wr
    function automatic logic [BUS_W-1:0] merge_bytes(
        input logic [BUS_W-1:0]  cur,
        input logic [BUS_W-1:0]  wr,
        input logic [STRB_W-1:0] strb
    );
        logic [BUS_W-1:0] res;
        for (int b = 0; b < STRB_W; b++) begin
            res[b*8 +: 8] = strb[b] ? wr[b*8 +: 8] : cur[b*8 +: 8];
        end
        return res;
    endfunction

endpackage

// File: rtl/sysctl_mtimer.sv
module sysctl_mtimer
    import sysctl_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              wr_time_lo_i,
    input  logic              wr_time_hi_i,
    input  logic              wr_cmp_lo_i,
    input  logic              wr_cmp_hi_i,
    input  logic [BUS_W-1:0]  wdata_i,
    input  logic [STRB_W-1:0] strb_i,
    output logic [TMR_W-1:0]  mtime_o,
    output logic [TMR_W-1:0]  cmp_o,
    output logic              irq_o
);

    localparam logic [TMR_W-1:0] ONE = {{(TMR_W-1){1'b0}}, 1'b1};

    tmr_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_time_lo_i || wr_time_hi_i) begin
            if (wr_time_lo_i)
                st_d.mtime[BUS_W-1:0] = merge_bytes(st_q.mtime[BUS_W-1:0], wdata_i, strb_i);
            if (wr_time_hi_i)
                st_d.mtime[TMR_W-1:BUS_W] = merge_bytes(st_q.mtime[TMR_W-1:BUS_W], wdata_i, strb_i);
        end else begin
            st_d.mtime = st_q.mtime + ONE;
        end
        if (wr_cmp_lo_i)
            st_d.cmp[BUS_W-1:0] = merge_bytes(st_q.cmp[BUS_W-1:0], wdata_i, strb_i);
        if (wr_cmp_hi_i)
            st_d.cmp[TMR_W-1:BUS_W] = merge_bytes(st_q.cmp[TMR_W-1:BUS_W], wdata_i, strb_i);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q.mtime <= '0;
            st_q.cmp   <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign mtime_o = st_q.mtime;
    assign cmp_o   = st_q.cmp;
    assign irq_o   = (st_q.mtime >= st_q.cmp);

    // ---------------- assertions ----------------
    logic past_valid_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) past_valid_q <= 1'b0;
        else         past_valid_q <= 1'b1;
    end

    assert_count_step_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (past_valid_q && !$past(wr_time_lo_i || wr_time_hi_i))
            |-> (mtime_o == $past(mtime_o) + ONE));

    assert_cmp_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(wr_cmp_lo_i || wr_cmp_hi_i) |=> $stable(cmp_o));

    assert_write_no_step_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_time_lo_i && strb_i == '1) |=> (mtime_o[BUS_W-1:0] == $past(wdata_i)));

endmodule

// File: rtl/sysctl_rdmux.sv
module sysctl_rdmux
    import sysctl_pkg::*;
#(
    parameter int         WIDX_W     = 6,
    parameter logic [7:0] VER_REV    = 8'h00,
    parameter logic [7:0] VER_MINOR  = 8'h00,
    parameter logic [7:0] VER_MAJOR  = 8'h00,
    parameter logic       VER_DIRTY  = 1'b0,
    parameter logic [31:0] BUILD_HASH = 32'h0
) (
    input  logic [WIDX_W-1:0] word_i,
    input  logic              gpio_i,
    input  logic              init_done_i,
    input  logic              init_err_i,
    input  logic [TMR_W-1:0]  mtime_i,
    input  logic [TMR_W-1:0]  cmp_i,
    output logic [BUS_W-1:0]  rdata_o
);

    localparam logic [BUS_W-1:0] ID_WORD = {VER_DIRTY, 7'b0, VER_MAJOR, VER_MINOR, VER_REV};

    always_comb begin
        rdata_o = '0;
        case (int'(word_i))
            W_ID:       rdata_o = ID_WORD;
            W_HASH:     rdata_o = BUILD_HASH;
            W_SIM:      rdata_o = {8'h00, 6'b0, init_err_i, init_done_i, 16'h0000};
            W_GPIO:     rdata_o = {{(BUS_W-1){1'b0}}, gpio_i};
            W_MTIME_LO: rdata_o = mtime_i[BUS_W-1:0];
            W_MTIME_HI: rdata_o = mtime_i[TMR_W-1:BUS_W];
            W_CMP_LO:   rdata_o = cmp_i[BUS_W-1:0];
            W_CMP_HI:   rdata_o = cmp_i[TMR_W-1:BUS_W];
            default:    rdata_o = '0;
        endcase
    end

endmodule

// File: rtl/sysctl.sv
module sysctl
    import sysctl_pkg::*;
#(
    parameter int          ADDR_W     = 8,
    parameter logic [7:0]  VER_REV    = 8'h01,
    parameter logic [7:0]  VER_MINOR  = 8'h00,
    parameter logic [7:0]  VER_MAJOR  = 8'h00,
    parameter logic        VER_DIRTY  = 1'b0,
    parameter logic [31:0] BUILD_HASH = 32'h0000_0000,
    parameter bit          SIM_HOOKS  = 1'b0
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              req_valid_i,
    input  logic              req_we_i,
    input  logic [ADDR_W-1:0] req_addr_i,
    input  logic [31:0]       req_wdata_i,
    input  logic [3:0]        req_strb_i,
    output logic [31:0]       rsp_rdata_o,
    input  logic              ram_init_done_i,
    input  logic              ram_init_err_i,
    output logic              gpio_o,
    output logic              timer_irq_o
);

    localparam int WIDX_W = ADDR_W - 2;
    localparam logic [BUS_W-1:0] ID_WORD = {VER_DIRTY, 7'b0, VER_MAJOR, VER_MINOR, VER_REV};

    logic [WIDX_W-1:0] word;
    logic [1:0]        unused_addr_lsb;
    logic              rd_en, wr_en;
    logic              wr_tlo, wr_thi, wr_clo, wr_chi;
    logic [TMR_W-1:0]  mtime, cmp;
    logic [BUS_W-1:0]  mux_data;

    ctl_state_t ctl_d, ctl_q;

    assign word            = req_addr_i[ADDR_W-1:2];
    assign unused_addr_lsb = req_addr_i[1:0];
    assign rd_en           = req_valid_i && !req_we_i;
    assign wr_en           = req_valid_i && req_we_i;

    assign wr_tlo = wr_en && (int'(word) == W_MTIME_LO);
    assign wr_thi = wr_en && (int'(word) == W_MTIME_HI);
    assign wr_clo = wr_en && (int'(word) == W_CMP_LO);
    assign wr_chi = wr_en && (int'(word) == W_CMP_HI);

    sysctl_mtimer u_mtimer (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .wr_time_lo_i (wr_tlo),
        .wr_time_hi_i (wr_thi),
        .wr_cmp_lo_i  (wr_clo),
        .wr_cmp_hi_i  (wr_chi),
        .wdata_i      (req_wdata_i),
        .strb_i       (req_strb_i),
        .mtime_o      (mtime),
        .cmp_o        (cmp),
        .irq_o        (timer_irq_o)
    );

    sysctl_rdmux #(
        .WIDX_W     (WIDX_W),
        .VER_REV    (VER_REV),
        .VER_MINOR  (VER_MINOR),
        .VER_MAJOR  (VER_MAJOR),
        .VER_DIRTY  (VER_DIRTY),
        .BUILD_HASH (BUILD_HASH)
    ) u_rdmux (
        .word_i      (word),
        .gpio_i      (ctl_q.gpio),
        .init_done_i (ram_init_done_i),
        .init_err_i  (ram_init_err_i),
        .mtime_i     (mtime),
        .cmp_i       (cmp),
        .rdata_o     (mux_data)
    );

    always_comb begin
        ctl_d = ctl_q;
        if (rd_en)
            ctl_d.rdata = mux_data;
        if (wr_en && (int'(word) == W_GPIO) && req_strb_i[0])
            ctl_d.gpio = req_wdata_i[0];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            ctl_q.gpio  <= 1'b0;
            ctl_q.rdata <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign rsp_rdata_o = ctl_q.rdata;
    assign gpio_o      = ctl_q.gpio;

    // Simulation hooks: print on lane 0, end run on lane 1 of the hook word
    generate
        if (SIM_HOOKS) begin : g_hooks
            always_ff @(posedge clk_i) begin
                if (rst_ni && wr_en && (int'(word) == W_SIM)) begin
                    if (req_strb_i[0]) $write("%c", req_wdata_i[7:0]);
                    if (req_strb_i[1]) $finish;
                end
            end
        end
    endgenerate

    // ---------------- assertions ----------------
    logic past_valid_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) past_valid_q <= 1'b0;
        else         past_valid_q <= 1'b1;
    end

    logic mapped;
    assign mapped = (int'(word) == W_ID)       || (int'(word) == W_HASH)     ||
                    (int'(word) == W_SIM)      || (int'(word) == W_GPIO)     ||
                    (int'(word) == W_MTIME_LO) || (int'(word) == W_MTIME_HI) ||
                    (int'(word) == W_CMP_LO)   || (int'(word) == W_CMP_HI);

    assert_id_read_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rd_en && int'(word) == W_ID) |=> (rsp_rdata_o == ID_WORD));

    assert_gpio_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(wr_en && int'(word) == W_GPIO) |=> $stable(gpio_o));

    assert_unmapped_zero_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rd_en && !mapped) |=> (rsp_rdata_o == '0));

    assert_rdata_hold_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !rd_en |=> $stable(rsp_rdata_o));

    assert_irq_rise_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (past_valid_q && $rose(timer_irq_o) && !$past(wr_tlo || wr_thi || wr_clo || wr_chi))
            |-> (mtime == cmp));

endmodule

// File: tb/sysctl_bench.sv
module sysctl_bench;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid, req_we;
    logic [7:0]  req_addr;
    logic [31:0] req_wdata;
    logic [3:0]  req_strb;
    logic [31:0] rsp_rdata;
    logic        init_done, init_err;
    logic        gpio, irq;

    int n_tests = 0;
    int n_fail  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sysctl #(
        .ADDR_W     (8),
        .VER_REV    (8'h11),
        .VER_MINOR  (8'h22),
        .VER_MAJOR  (8'h33),
        .VER_DIRTY  (1'b1),
        .BUILD_HASH (32'hCAFE_F00D),
        .SIM_HOOKS  (1'b0)
    ) u_sysctl (
        .clk_i           (clk),
        .rst_ni          (rst_n),
        .req_valid_i     (req_valid),
        .req_we_i        (req_we),
        .req_addr_i      (req_addr),
        .req_wdata_i     (req_wdata),
        .req_strb_i      (req_strb),
        .rsp_rdata_o     (rsp_rdata),
        .ram_init_done_i (init_done),
        .ram_init_err_i  (init_err),
        .gpio_o          (gpio),
        .timer_irq_o     (irq)
    );

    typedef struct packed {
        logic        we;
        logic [7:0]  addr;
        logic [31:0] wdata;
        logic [3:0]  strb;
        logic [31:0] exp;
        logic        gpio;
    } vec_t;

    localparam int NVEC = 17;
    // Run with init_done=1, init_err=1
    localparam vec_t VECS [NVEC] = '{
        '{1'b0, 8'h00, 32'h0,          4'h0, 32'h8033_2211, 1'b0}, // R1
        '{1'b0, 8'h04, 32'h0,          4'h0, 32'hCAFE_F00D, 1'b0}, // R2
        '{1'b1, 8'h00, 32'hFFFF_FFFF,  4'hF, 32'h0,         1'b0}, // R1 write ignored
        '{1'b0, 8'h00, 32'h0,          4'h0, 32'h8033_2211, 1'b0}, // R1
        '{1'b0, 8'h08, 32'h0,          4'h0, 32'h0003_0000, 1'b0}, // R3
        '{1'b1, 8'h10, 32'h1,          4'h1, 32'h0,         1'b1}, // R5
        '{1'b0, 8'h10, 32'h0,          4'h0, 32'h0000_0001, 1'b1}, // R5
        '{1'b1, 8'h10, 32'h0,          4'h0, 32'h0,         1'b1}, // R10 no lane
        '{1'b0, 8'h10, 32'h0,          4'h0, 32'h0000_0001, 1'b1}, // R10
        '{1'b1, 8'h10, 32'hFFFF_FFFE,  4'hF, 32'h0,         1'b0}, // R5
        '{1'b0, 8'h10, 32'h0,          4'h0, 32'h0,         1'b0}, // R5
        '{1'b0, 8'h0C, 32'h0,          4'h0, 32'h0,         1'b0}, // R11
        '{1'b0, 8'h30, 32'h0,          4'h0, 32'h0,         1'b0}, // R11
        '{1'b1, 8'h28, 32'h1234_5678,  4'h5, 32'h0,         1'b0}, // R10
        '{1'b0, 8'h28, 32'h0,          4'h0, 32'hFF34_FF78, 1'b0}, // R10
        '{1'b1, 8'h08, 32'h0000_0141,  4'h3, 32'h0,         1'b0}, // R4
        '{1'b0, 8'h08, 32'h0,          4'h0, 32'h0003_0000, 1'b0}  // R4
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Each bus op occupies exactly one clock edge; called just after an edge.
    task automatic bus_wr(input logic [7:0] a, input logic [31:0] d, input logic [3:0] s);
        req_valid = 1'b1; req_we = 1'b1; req_addr = a; req_wdata = d; req_strb = s;
        @(posedge clk); #1;
        req_valid = 1'b0; req_we = 1'b0;
    endtask

    task automatic bus_rd(input logic [7:0] a, output logic [31:0] d);
        req_valid = 1'b1; req_we = 1'b0; req_addr = a; req_strb = 4'h0;
        @(posedge clk); #1;
        req_valid = 1'b0;
        d = rsp_rdata;
    endtask

    task automatic tick();
        @(posedge clk); #1;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] rd;
        rst_n = 1'b0; req_valid = 1'b0; req_we = 1'b0; req_addr = '0;
        req_wdata = '0; req_strb = '0; init_done = 1'b1; init_err = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // Reset state
        check("R12 rdata after reset", rsp_rdata, 32'h0);
        check("R5 gpio after reset", {31'b0, gpio}, 32'h0);
        check("R9 irq after reset", {31'b0, irq}, 32'h0);
        bus_rd(8'h20, rd); check("R6 mtime reset 0", rd, 32'd0);
        bus_rd(8'h20, rd); check("R6 mtime +1", rd, 32'd1);
        bus_rd(8'h24, rd); check("R6 mtime hi reset", rd, 32'd0);
        bus_rd(8'h28, rd); check("R8 cmp lo reset", rd, 32'hFFFF_FFFF);
        bus_rd(8'h2C, rd); check("R8 cmp hi reset", rd, 32'hFFFF_FFFF);

        // Vector table
        for (int i = 0; i < NVEC; i++) begin
            if (VECS[i].we) begin
                bus_wr(VECS[i].addr, VECS[i].wdata, VECS[i].strb);
            end else begin
                bus_rd(VECS[i].addr, rd);
                check($sformatf("R1-table vec %0d", i), rd, VECS[i].exp);
            end
            check($sformatf("R5 gpio vec %0d", i), {31'b0, gpio}, {31'b0, VECS[i].gpio});
        end

        // R3 live status inputs
        init_done = 1'b1; init_err = 1'b0;
        bus_rd(8'h08, rd); check("R3 done only", rd, 32'h0001_0000);
        init_done = 1'b0;
        bus_rd(8'h08, rd); check("R3 none", rd, 32'h0);

        // R12 hold across idle and write
        bus_rd(8'h04, rd);
        tick(); tick();
        check("R12 hold idle", rsp_rdata, 32'hCAFE_F00D);
        bus_wr(8'h10, 32'h0, 4'h1);
        check("R12 hold write", rsp_rdata, 32'hCAFE_F00D);

        // R7 write wins over increment
        bus_wr(8'h20, 32'd500, 4'hF);
        bus_rd(8'h20, rd); check("R7 written value", rd, 32'd500);
        bus_rd(8'h20, rd); check("R7 resumes", rd, 32'd501);

        // R6 carry low->high
        bus_wr(8'h24, 32'h0, 4'hF);
        bus_wr(8'h20, 32'hFFFF_FFFF, 4'hF);
        bus_rd(8'h20, rd); check("R6 lo max", rd, 32'hFFFF_FFFF);
        bus_rd(8'h24, rd); check("R6 carry hi", rd, 32'h1);

        // R9 compare crossing
        bus_wr(8'h24, 32'h0, 4'hF);
        bus_wr(8'h20, 32'd100, 4'hF);
        bus_wr(8'h2C, 32'h0, 4'hF);
        bus_wr(8'h28, 32'd110, 4'hF);   // mtime now 102
        check("R9 below cmp", {31'b0, irq}, 32'h0);
        repeat (7) tick();               // mtime 109
        check("R9 one below", {31'b0, irq}, 32'h0);
        tick();                          // mtime 110
        check("R9 equal", {31'b0, irq}, 32'h1);
        tick();                          // mtime 111
        check("R9 above", {31'b0, irq}, 32'h1);
        bus_wr(8'h2C, 32'h1, 4'hF);
        check("R8 R9 cmp raised", {31'b0, irq}, 32'h0);
        bus_rd(8'h2C, rd); check("R8 cmp hi readback", rd, 32'h1);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule